// File: doc/BRIEF.md
# Master Audio Frame Clock Generator

This block produces the timing clocks that a master-side serial audio port drives toward a converter: a bit clock, a left/right frame clock for the playback (DAC) path, an identical frame clock for the record (ADC) path, and a one-cycle frame-start strobe. Every output is derived from a single master clock. Serial data shifting is handled elsewhere. The data shifters use the strobe and the frame clocks to find word boundaries.

Two timing modes exist. In divided mode the bit clock is an even division of the master clock, set by a divider input. A frame spans a parameterised number of bit clocks (64 by default), and the frame clock stays at its left level for exactly half of them. In fixed-rate mode the master clock (for example 12 MHz) is passed through as the bit clock. The frame is then an odd number of master cycles (375 by default, giving 32 kHz). That odd length forces a split that is one cycle shorter on the left side than on the right.

In both modes the frame clock changes only at instants where the bit clock falls. Mode and divider inputs are sampled at frame boundaries only, so a reconfiguration never cuts a frame short and never produces a runt pulse.

Top module: `afc_frame_clock_gen`

## Requirements
- R1: While `rst_n_i` is low, `bclk_o`, `dac_lrc_o`, `adc_lrc_o` and `frame_start_o` are all 0, in either mode.
- R2: In divided mode (`fixed_mode_i` = 0) with effective divider D, `bclk_o` is low for D master cycles and then high for D master cycles, repeating. The first low phase begins at the first cycle of each frame.
- R3: In divided mode a frame lasts 2*BITS_PER_FRAME*D master cycles. With LEFT_HIGH = 1 the frame clock is 1 for the first BITS_PER_FRAME*D cycles and 0 for the rest, which is an exact 50:50 ratio.
- R4: In fixed-rate mode (`fixed_mode_i` = 1), `bclk_o` is the inverted master clock: 1 while `mclk_i` is low and 0 while it is high. The divider input has no effect in this mode.
- R5: In fixed-rate mode a frame lasts FIX_LEN master cycles. The frame clock is 1 for the first FIX_LEN/2 cycles (rounded down; 187 when FIX_LEN = 375) and 0 for the remaining cycles (188).
- R6: The frame clock changes only on a rising master-clock edge at which `bclk_o` goes from 1 to 0.
- R7: `dac_lrc_o` and `adc_lrc_o` are equal at all times.
- R8: `frame_start_o` is 1 for exactly the first master cycle of each frame, and the frame clock is at its left level in that cycle. The first frame starts in the cycle that follows the first rising edge at which reset is released.
- R9: A change on `fixed_mode_i` or `bclk_div_i` does not affect the frame in progress. It takes effect from the next frame start.
- R10: A divider value of 0 behaves exactly like a divider value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; all state changes on its rising edge |
| rst_n_i | input | 1 | Synchronous active-low reset |
| fixed_mode_i | input | 1 | 0: divided mode, 1: fixed-rate mode (sampled at frame boundaries) |
| bclk_div_i | input | DIV_W | Bit-clock half-period in master cycles, divided mode (0 treated as 1) |
| bclk_o | output | 1 | Bit clock |
| dac_lrc_o | output | 1 | Playback-path left/right frame clock |
| adc_lrc_o | output | 1 | Record-path left/right frame clock, phase-aligned with dac_lrc_o |
| frame_start_o | output | 1 | One-master-cycle strobe in the first cycle of each frame |

## Verification
All outputs are registered state or the master clock itself, so each result is due in the master cycle that follows the rising edge causing it. The bench samples one time unit after every falling edge, in the middle of the cycle, and compares against a position index that it counts from the strobe. The first strobe is expected in the first low phase after the first rising edge with reset released. A configuration change is driven one third of the way into a frame: the remainder of that frame is checked against the old settings, and the new settings are expected from the next strobe onward. In fixed-rate mode the bit clock is also sampled in the high phase of the master clock, because its value there is the opposite of its value in the low phase.

// File: rtl/afc_pkg.sv
package afc_pkg;

   typedef enum logic {
      AFC_DIVIDED = 1'b0,
      AFC_FIXED   = 1'b1
   } afc_mode_e;

   function automatic int unsigned afc_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/afc_cfg_latch.sv
module afc_cfg_latch
   import afc_pkg::*;
#(
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             load_i,
   input  afc_mode_e        mode_i,
   input  logic [DIV_W-1:0] div_i,
   output afc_mode_e        mode_o,
   output logic [DIV_W-1:0] div_o
);

   logic [DIV_W-1:0] div_eff;
   afc_mode_e        mode_q;
   logic [DIV_W-1:0] div_q;

   // zero divider maps onto the fastest legal setting (R10)
   assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;

   // while in reset the settings follow the inputs; afterwards only at frame wrap
   always_ff @(posedge clk_i) begin
      if (!rst_n_i || load_i) begin
         mode_q <= mode_i;
         div_q  <= div_eff;
      end
   end

   assign mode_o = mode_q;
   assign div_o  = div_q;

   p_cfg_hold_r9 : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($past(rst_n_i) && !$past(load_i)) |-> ($stable(mode_q) && $stable(div_q)))
      else $error("active configuration moved inside a frame");

   p_div_nonzero_r10 : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $past(rst_n_i) |-> (div_q != '0))
      else $error("active divider is zero");

endmodule

// File: rtl/afc_bit_phase.sv
module afc_bit_phase
   import afc_pkg::*;
#(
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             run_i,
   input  logic             wrap_i,
   input  afc_mode_e        mode_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             phase_o
);

   logic [DIV_W-1:0] sub_q;
   logic             phase_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i || !run_i || wrap_i) begin
         sub_q   <= '0;
         phase_q <= 1'b0;
      end else if (mode_i == AFC_FIXED) begin
         // parked high so a later switch to divided mode starts on a falling edge
         sub_q   <= '0;
         phase_q <= 1'b1;
      end else if (sub_q == div_i - 1'b1) begin
         sub_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         sub_q   <= sub_q + 1'b1;
      end
   end

   assign phase_o = phase_q;

   p_sub_bound_r2 : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (run_i && mode_i == AFC_DIVIDED) |-> (sub_q < div_i))
      else $error("bit phase counter beyond divider");

endmodule

// File: rtl/afc_frame_ctr.sv
module afc_frame_ctr
   import afc_pkg::*;
#(
   parameter int unsigned BITS_PER_FRAME = 64,
   parameter int unsigned DIV_W          = 4,
   parameter int unsigned FIX_LEN        = 375
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             run_i,
   input  afc_mode_e        mode_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             wrap_o,
   output logic             at_start_o,
   output logic             first_half_o
);

   localparam int unsigned NORM_MAX = 2 * BITS_PER_FRAME * ((1 << DIV_W) - 1);
   localparam int unsigned MAX_LEN  = afc_max(NORM_MAX, FIX_LEN);
   localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1);

   logic [LEN_W-1:0] len;
   logic [LEN_W-1:0] half;
   logic [LEN_W-1:0] pos_q;

   always_comb begin
      if (mode_i == AFC_FIXED) begin
         len  = LEN_W'(FIX_LEN);
         half = LEN_W'(FIX_LEN / 2);
      end else begin
         len  = LEN_W'(2 * BITS_PER_FRAME) * LEN_W'(div_i);
         half = LEN_W'(BITS_PER_FRAME) * LEN_W'(div_i);
      end
   end

   assign wrap_o = run_i && (pos_q == len - 1'b1);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i || !run_i || wrap_o) begin
         pos_q <= '0;
      end else begin
         pos_q <= pos_q + 1'b1;
      end
   end

   assign at_start_o   = run_i && (pos_q == '0);
   assign first_half_o = (pos_q < half);

   p_pos_in_range_r3 : assert property (@(posedge clk_i) disable iff (!rst_n_i)
      run_i |-> (pos_q < len))
      else $error("frame position past frame length");

endmodule

// File: rtl/afc_frame_clock_gen.sv
module afc_frame_clock_gen
   import afc_pkg::*;
#(
   parameter int unsigned BITS_PER_FRAME = 64,
   parameter int unsigned DIV_W          = 4,
   parameter int unsigned FIX_LEN        = 375,
   parameter bit          LEFT_HIGH      = 1'b1
) (
   input  logic             mclk_i,
   input  logic             rst_n_i,
   input  logic             fixed_mode_i,
   input  logic [DIV_W-1:0] bclk_div_i,
   output logic             bclk_o,
   output logic             dac_lrc_o,
   output logic             adc_lrc_o,
   output logic             frame_start_o
);

   localparam int unsigned NUM_LRC = 2;

   if (BITS_PER_FRAME < 2 || (BITS_PER_FRAME % 2) != 0) begin : g_chk_bpf
      $error("BITS_PER_FRAME must be even and at least 2");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_chk_div
      $error("DIV_W must lie between 1 and 8");
   end
   if (FIX_LEN < 3 || (FIX_LEN % 2) == 0) begin : g_chk_fix
      $error("FIX_LEN must be odd and at least 3");
   end

   logic             run_q;
   afc_mode_e        act_mode;
   logic [DIV_W-1:0] act_div;
   logic             wrap;
   logic             at_start;
   logic             first_half;
   logic             phase;
   logic             lrc_lvl;
   logic [NUM_LRC-1:0] lrc_vec;

   always_ff @(posedge mclk_i) begin
      if (!rst_n_i) run_q <= 1'b0;
      else          run_q <= 1'b1;
   end

   afc_cfg_latch #(.DIV_W(DIV_W)) u_cfg (
      .clk_i   (mclk_i),
      .rst_n_i (rst_n_i),
      .load_i  (wrap),
      .mode_i  (afc_mode_e'(fixed_mode_i)),
      .div_i   (bclk_div_i),
      .mode_o  (act_mode),
      .div_o   (act_div)
   );

   afc_frame_ctr #(
      .BITS_PER_FRAME (BITS_PER_FRAME),
      .DIV_W          (DIV_W),
      .FIX_LEN        (FIX_LEN)
   ) u_frame (
      .clk_i        (mclk_i),
      .rst_n_i      (rst_n_i),
      .run_i        (run_q),
      .mode_i       (act_mode),
      .div_i        (act_div),
      .wrap_o       (wrap),
      .at_start_o   (at_start),
      .first_half_o (first_half)
   );

   afc_bit_phase #(.DIV_W(DIV_W)) u_phase (
      .clk_i   (mclk_i),
      .rst_n_i (rst_n_i),
      .run_i   (run_q),
      .wrap_i  (wrap),
      .mode_i  (act_mode),
      .div_i   (act_div),
      .phase_o (phase)
   );

   if (LEFT_HIGH) begin : g_left_high
      assign lrc_lvl = run_q & first_half;
   end else begin : g_left_low
      assign lrc_lvl = run_q & ~first_half;
   end

   for (genvar k = 0; k < NUM_LRC; k++) begin : g_lrc
      assign lrc_vec[k] = lrc_lvl;
   end

   assign dac_lrc_o     = lrc_vec[0];
   assign adc_lrc_o     = lrc_vec[1];
   assign frame_start_o = at_start;

   // fixed-rate: inverted master clock, so every rising master edge is a falling bit-clock edge
   assign bclk_o = run_q & ((act_mode == AFC_FIXED) ? ~mclk_i : phase);

   p_lrc_on_bclk_fall_r6 : assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      ($past(run_q) && act_mode == AFC_DIVIDED && (dac_lrc_o != $past(dac_lrc_o)))
      |-> ($past(phase) && !phase))
      else $error("frame clock moved away from a falling bit-clock edge");

   p_strobe_single_r8 : assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      frame_start_o |=> !frame_start_o)
      else $error("frame strobe wider than one cycle");

   p_strobe_left_r8 : assert property (@(posedge mclk_i) disable iff (!rst_n_i)
      frame_start_o |-> first_half)
      else $error("frame strobe outside the left half");

   p_reset_quiet_r1 : assert property (@(posedge mclk_i)
      !rst_n_i |=> (!run_q || rst_n_i))
      else $error("run flag set during reset");

endmodule

// File: tb/afc_frame_clock_gen_test.sv
module afc_frame_clock_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int BPF        = 64;
   localparam int DW         = 4;
   localparam int FL         = 375;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fixed = 1'b0;
   logic [DW-1:0] div = '0;
   logic          bclk, dac_lrc, adc_lrc, fstart;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   logic prev_b = 1'b0;
   logic prev_l = 1'b0;
   bit  first_frame = 1'b1;

   afc_frame_clock_gen #(
      .BITS_PER_FRAME (BPF),
      .DIV_W          (DW),
      .FIX_LEN        (FL),
      .LEFT_HIGH      (1'b1)
   ) uut (
      .mclk_i        (clk),
      .rst_n_i       (rst_n),
      .fixed_mode_i  (fixed),
      .bclk_div_i    (div),
      .bclk_o        (bclk),
      .dac_lrc_o     (dac_lrc),
      .adc_lrc_o     (adc_lrc),
      .frame_start_o (fstart)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input string what, input bit bad,
                        input int act, input int exp);
      n_cmp++;
      if (bad) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Entered at the sample point of a frame's first cycle; leaves at the next frame's first cycle.
   task automatic run_frame(input bit f, input int d, input bit nf, input int nd);
      int e    = (d == 0) ? 1 : d;
      int len  = f ? FL : 2 * BPF * e;
      int half = f ? FL / 2 : BPF * e;
      bit hl = 0, hb = 0, hs = 0, hm = 0, he = 0, hp = 0;
      int al = 0, xl = 0, ab = 0, xb = 0, as_ = 0, xs = 0, il = 0, ib = 0, is_ = 0;
      int am = 0, ie = 0, ap = 0;
      string tag_l = f ? "R5" : ((d == 0) ? "R3/R9/R10" : "R3/R9");
      string tag_b = f ? "R4" : ((d == 0) ? "R2/R10" : "R2");
      for (int i = 0; i < len; i++) begin
         int exp_l = (i < half) ? 1 : 0;
         int exp_b = f ? 1 : (((i / e) % 2) == 1 ? 1 : 0);
         int exp_s = (i == 0) ? 1 : 0;
         if (int'(dac_lrc) != exp_l && !hl) begin hl = 1; al = dac_lrc; xl = exp_l; il = i; end
         if (int'(bclk) != exp_b && !hb) begin hb = 1; ab = bclk; xb = exp_b; ib = i; end
         if (int'(fstart) != exp_s && !hs) begin hs = 1; as_ = fstart; xs = exp_s; is_ = i; end
         if (dac_lrc !== adc_lrc && !hm) begin hm = 1; am = adc_lrc; end
         if (!f && !first_frame && dac_lrc != prev_l && !(prev_b == 1'b1 && bclk == 1'b0) && !he) begin
            he = 1; ie = i;
         end
         prev_b = bclk;
         prev_l = dac_lrc;
         first_frame = 1'b0;
         if (i == len / 3) begin
            fixed = nf;
            div   = DW'(nd);
         end
         if (f && i == 1) begin
            @(posedge clk); #1;
            if (bclk !== 1'b0 && !hp) begin hp = 1; ap = bclk; end
         end
         @(negedge clk); #1;
      end
      check(tag_l, $sformatf("frame clock mode=%0d div=%0d at pos %0d", f, d, il), hl, al, xl);
      check(tag_b, $sformatf("bit clock mode=%0d div=%0d at pos %0d", f, d, ib), hb, ab, xb);
      check("R8", $sformatf("frame strobe mode=%0d div=%0d at pos %0d", f, d, is_), hs, as_, xs);
      check("R7", $sformatf("adc frame clock vs dac mode=%0d div=%0d", f, d), hm, am, 1 - am);
      if (f) check("R4", "bit clock in master-clock high phase", hp, ap, 0);
      else   check("R6", $sformatf("frame clock edge not on bit-clock fall div=%0d pos %0d", d, ie), he, 1, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R8 watchdog expired actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      fixed = 1'b1;
      div   = DW'(5);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R1: quiet outputs in reset, fixed mode, both clock phases
      check("R1", "bclk in reset (low phase)", bclk !== 1'b0, bclk, 0);
      check("R1", "dac lrc in reset", dac_lrc !== 1'b0, dac_lrc, 0);
      check("R1", "adc lrc in reset", adc_lrc !== 1'b0, adc_lrc, 0);
      check("R1", "strobe in reset", fstart !== 1'b0, fstart, 0);
      @(posedge clk); #1;
      check("R1", "bclk in reset (high phase)", bclk !== 1'b0, bclk, 0);
      @(negedge clk); #1;
      fixed = 1'b0;
      div   = DW'(2);
      @(negedge clk); #1;
      rst_n = 1'b1;
      check("R8", "no strobe before first edge out of reset", fstart !== 1'b0, fstart, 0);
      @(negedge clk); #1;
      // first frame starts here
      run_frame(1'b0, 2, 1'b0, 0);
      run_frame(1'b0, 0, 1'b1, 7);
      run_frame(1'b1, 7, 1'b0, 1);
      for (int d = 1; d <= 15; d++) begin
         run_frame(1'b0, d, (d == 15), (d == 15) ? 0 : d + 1);
      end
      run_frame(1'b1, 0, 1'b1, 3);
      run_frame(1'b1, 3, 1'b0, 4);
      run_frame(1'b0, 4, 1'b0, 4);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule